// File: doc/BRIEF.md
# SPI Memory-Mapped Access Master

This block is an SPI master that lets on-chip logic read and write the register and memory space of an external graphics controller. A request carries a direction, an address of up to 22 bits and a byte count; the block builds the header, streams the data, and drives chip select, the serial clock and the data-out line itself. Write data is taken one data word at a time through a valid/ready handshake, and read data is handed back one word at a time with a single-cycle valid pulse. Multi-byte values travel least-significant byte first, so byte lane 0 of a word is always the first byte on the wire.

A second request kind, selected by `cmd_mode`, sends a three-byte control frame (one command byte and two zero bytes) to the controller. The serial clock rate is chosen per transaction from two parameterised half-periods, so bring-up can run slowly and later traffic can run fast.

Top module: `spi_mmap_master`

## Requirements
- R1: While reset is held and right after it, `cs_n` is 1 and `sck`, `busy`, `wready` and `rvalid` are 0.
- R2: Clock polarity and phase are both zero: `sck` rests low, each byte goes most significant bit first, `mosi` only changes while `sck` is low, and `miso` is sampled on the rising edge of `sck`.
- R3: `cs_n` drops in the cycle after an accepted `start`, stays low until the last bit of the transaction has been clocked, and is 1 whenever `busy` is 0; `sck` is low while `cs_n` is 1.
- R4: A write (`rw`=1, `cmd_mode`=0) sends the byte {1, 0, addr[21:16]}, then addr[15:8], then addr[7:0], then `len`+1 data bytes, all under one chip select.
- R5: A read (`rw`=0, `cmd_mode`=0) sends {0, 0, addr[21:16]}, addr[15:8], addr[7:0], one dummy zero byte whose `miso` content is dropped, then `len`+1 zero bytes whose `miso` content is the read data.
- R6: Data bytes map to byte lanes least significant first: data byte k uses lane k mod 4 of the current 32-bit word. On reads `rvalid` pulses for one cycle when lane 3 is filled and after the final byte; a partial last word has its unfilled lanes at zero.
- R7: Bursts send no header after the first; a new write word is requested with `wready` before data bytes 0, 4, 8 and so on, and while `wready` is high and no word is given `sck` stays low and `cs_n` stays low.
- R8: With `cmd_mode`=1 the frame is addr[7:0] followed by two zero bytes under its own chip select; `rw` and `len` have no effect.
- R9: A `start` while `busy` is 1 is ignored: the running transaction's bytes do not change and no extra chip-select frame follows.
- R10: Each `sck` high and low phase lasts `FAST_HALF` clocks if `fast_sel` was 1 when the transaction was accepted, else `SLOW_HALF` clocks; changes to `fast_sel` while `busy` is 1 have no effect.
- R11: Between two transactions `cs_n` stays high for at least one half-period of the transaction that just ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when idle |
| rw | input | 1 | 1 = write, 0 = read |
| cmd_mode | input | 1 | 1 = send a three-byte control frame |
| addr | input | ADDR_W | Target address; low byte is the command in control mode |
| len | input | LEN_W | Number of data bytes minus one |
| fast_sel | input | 1 | 1 = fast serial clock for the next transaction |
| wdata | input | DATA_W | Write data word, lane 0 sent first |
| wvalid | input | 1 | Write word available |
| wready | output | 1 | Master is waiting for a write word |
| rdata | output | DATA_W | Assembled read word |
| rvalid | output | 1 | One-cycle pulse, `rdata` holds a word |
| busy | output | 1 | Transaction or chip-select gap in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Chip select, active low |

## Verification
Two functions meet in one cycle when a new `start` and a `fast_sel` flip land in the middle of a running slow read: the request logic must reject the pulse while the rate latch must keep its captured value. The bench provokes this during a single-byte read and judges it by decoding every byte on the lines, counting chip-select frames and measuring each high phase of `sck`. The other collision is a byte boundary that is also a word boundary of a write burst, where the stall must begin instead of the next byte; the bench holds back the second word and checks that `sck` stays low for the whole wait.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XFER  = 2'd1,
      ST_LOADW = 2'd2,
      ST_GAP   = 2'd3
   } spim_st_t;

   function automatic int spim_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spim_tick.sv
module spim_tick #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] half,
   output logic             tick
);
   logic [CNT_W-1:0] cnt_q;

   assign tick = en && (cnt_q == half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spim_byte_sr.sv
module spim_byte_sr #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [BW-1:0] load_val,
   input  logic          rise,
   input  logic          fall,
   input  logic          miso,
   output logic          mosi,
   output logic          last_bit,
   output logic [BW-1:0] rx_byte
);
   localparam int BC_W = $clog2(BW);

   logic [BW-1:0]   tx_q;
   logic [BW-1:0]   rx_q;
   logic [BC_W-1:0] bc_q;

   assign mosi     = tx_q[BW-1];
   assign last_bit = (bc_q == BC_W'(BW - 1));
   assign rx_byte  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         bc_q <= '0;
      end else if (load) begin
         tx_q <= load_val;
         bc_q <= '0;
      end else if (fall && !last_bit) begin
         tx_q <= {tx_q[BW-2:0], 1'b0};
         bc_q <= bc_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx_q <= '0;
      else if (rise) rx_q <= {rx_q[BW-2:0], miso};
   end
endmodule

// File: rtl/spi_mmap_master.sv
module spi_mmap_master
   import spim_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 8,
   parameter int SLOW_HALF = 10,
   parameter int FAST_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rw,
   input  logic              cmd_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              fast_sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wvalid,
   output logic              wready,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   localparam int BYTES  = DATA_W / 8;
   localparam int LANE_W = $clog2(BYTES);
   localparam int HP_MAX = spim_max(SLOW_HALF, FAST_HALF);
   localparam int HP_W   = $clog2(HP_MAX + 1);
   localparam int POS_W  = LEN_W + 2;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_err_data
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if ((BYTES & (BYTES - 1)) != 0) begin : g_err_lanes
      $error("DATA_W/8 must be a power of two");
   end
   if (ADDR_W < 8 || ADDR_W > 22) begin : g_err_addr
      $error("ADDR_W must lie between 8 and 22");
   end
   if (SLOW_HALF < 1 || FAST_HALF < 1) begin : g_err_half
      $error("half-periods must be at least one clock");
   end

   spim_st_t          st_q;
   logic              wr_q, cmd_q, ph_q, cs_n_q, rvalid_q;
   logic [15:0]       mid_q;
   logic [LEN_W-1:0]  len_q;
   logic [HP_W-1:0]   hp_q;
   logic [POS_W-1:0]  pos_q;
   logic [DATA_W-1:0] wbuf_q;

   logic [23:0]       hdr_in;
   logic [7:0]        first_byte;
   logic [POS_W-1:0]  hdr_n, last_pos, nxt_pos;
   logic [LANE_W-1:0] lane_nxt, lane_cur;
   logic              is_data_nxt, is_data_cur, need_word;
   logic              tick, rise, fall, byte_end, last_bit, rd_cap;
   logic              sr_load;
   logic [7:0]        sr_val, nb, rx_byte;
   logic [7:0]        wlane [BYTES];

   // header of an incoming request: direction flag on top, address below
   assign hdr_in     = {rw, 23'(addr)};
   assign first_byte = cmd_mode ? addr[7:0] : hdr_in[23:16];

   assign hdr_n    = (cmd_q || wr_q) ? POS_W'(3) : POS_W'(4);
   assign last_pos = cmd_q ? POS_W'(2) : hdr_n + POS_W'(len_q);
   assign nxt_pos  = pos_q + 1'b1;

   assign lane_nxt    = LANE_W'(nxt_pos - hdr_n);
   assign lane_cur    = LANE_W'(pos_q - hdr_n);
   assign is_data_nxt = !cmd_q && (nxt_pos >= hdr_n);
   assign is_data_cur = !cmd_q && (pos_q >= hdr_n);
   assign need_word   = wr_q && is_data_nxt && (lane_nxt == '0);

   assign rise     = (st_q == ST_XFER) && tick && !ph_q;
   assign fall     = (st_q == ST_XFER) && tick && ph_q;
   assign byte_end = fall && last_bit;
   assign rd_cap   = byte_end && !wr_q && is_data_cur;

   // next byte after the current one within a transaction
   always_comb begin
      nb = '0;
      if (!cmd_q) begin
         if (nxt_pos == POS_W'(1))      nb = mid_q[15:8];
         else if (nxt_pos == POS_W'(2)) nb = mid_q[7:0];
         else if (wr_q && is_data_nxt)  nb = wlane[lane_nxt];
      end
   end

   assign sr_load = (st_q == ST_IDLE && start)
                 || (st_q == ST_LOADW && wvalid)
                 || (byte_end && pos_q != last_pos && !need_word);

   always_comb begin
      case (st_q)
         ST_IDLE:  sr_val = first_byte;
         ST_LOADW: sr_val = wdata[7:0];
         default:  sr_val = nb;
      endcase
   end

   spim_tick #(.CNT_W(HP_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (st_q == ST_XFER || st_q == ST_GAP),
      .half (hp_q),
      .tick (tick)
   );

   spim_byte_sr #(.BW(8)) u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sr_load),
      .load_val(sr_val),
      .rise    (rise),
      .fall    (fall),
      .miso    (miso),
      .mosi    (mosi),
      .last_bit(last_bit),
      .rx_byte (rx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wr_q   <= 1'b0;
         cmd_q  <= 1'b0;
         mid_q  <= '0;
         len_q  <= '0;
         hp_q   <= HP_W'(SLOW_HALF);
         pos_q  <= '0;
         ph_q   <= 1'b0;
         cs_n_q <= 1'b1;
         wbuf_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_XFER;
               wr_q   <= rw;
               cmd_q  <= cmd_mode;
               mid_q  <= hdr_in[15:0];
               len_q  <= len;
               hp_q   <= fast_sel ? HP_W'(FAST_HALF) : HP_W'(SLOW_HALF);
               pos_q  <= '0;
               ph_q   <= 1'b0;
               cs_n_q <= 1'b0;
            end
            ST_XFER: begin
               if (rise) ph_q <= 1'b1;
               if (fall) ph_q <= 1'b0;
               if (byte_end) begin
                  if (pos_q == last_pos) begin
                     st_q   <= ST_GAP;
                     cs_n_q <= 1'b1;
                  end else begin
                     pos_q <= nxt_pos;
                     if (need_word) st_q <= ST_LOADW;
                  end
               end
            end
            ST_LOADW: if (wvalid) begin
               wbuf_q <= wdata;
               st_q   <= ST_XFER;
            end
            ST_GAP: if (tick) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q <= '0;
         else if (rd_cap) begin
            if (lane_cur == LANE_W'(g)) lane_q <= rx_byte;
            else if (lane_cur == '0)    lane_q <= '0;
         end
      end
      assign rdata[8*g +: 8] = lane_q;
      assign wlane[g]        = wbuf_q[8*g +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= rd_cap && (lane_cur == LANE_W'(BYTES - 1) || pos_q == last_pos);
   end

   assign rvalid = rvalid_q;
   assign wready = (st_q == ST_LOADW);
   assign busy   = (st_q != ST_IDLE);
   assign sck    = ph_q;
   assign cs_n   = cs_n_q;
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
   parameter int HP_MAX = 10
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic mosi,
   input logic busy,
   input logic wready,
   input logic rvalid
);
   logic [15:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_run <= '0;
      else if (sck) hi_run <= hi_run + 1'b1;
      else          hi_run <= '0;
   end

   AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R3
   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n); // R3
   AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi)); // R2
   AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n) wready |-> (!sck && !cs_n)); // R7
   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rvalid |=> !rvalid); // R6
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R11
   AST_HALF_MAX: assert property (@(posedge clk) disable iff (!rst_n) sck |-> (32'(hi_run) < HP_MAX)); // R10
endmodule

bind spi_mmap_master spim_chk #(.HP_MAX(HP_MAX)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .sck   (sck),
   .mosi  (mosi),
   .busy  (busy),
   .wready(wready),
   .rvalid(rvalid)
);

// File: tb/sim_spi_mmap_master.sv
module sim_spi_mmap_master;
   localparam int SH = 6;
   localparam int FH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, rw = 1'b0, cmd_mode = 1'b0, fast_sel = 1'b0;
   logic [21:0] addr = '0;
   logic [7:0]  len = '0;
   logic [31:0] wdata = '0;
   logic        wvalid = 1'b0;
   logic        wready, rvalid, busy, sck, mosi, cs_n;
   logic        miso = 1'b0;
   logic [31:0] rdata;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   spi_mmap_master #(.SLOW_HALF(SH), .FAST_HALF(FH)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .cmd_mode(cmd_mode),
      .addr(addr), .len(len), .fast_sel(fast_sel), .wdata(wdata), .wvalid(wvalid),
      .wready(wready), .rdata(rdata), .rvalid(rvalid), .busy(busy), .sck(sck),
      .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // behavioural peripheral: decodes mosi, answers from mb[]
   logic [7:0] mb [0:15];
   logic [7:0] got [$];
   logic [7:0] rxb = '0;
   int bi = 0, bc = 0;
   logic last_sck = 1'b0;

   always @(negedge cs_n or posedge sck or negedge sck) begin
      if (sck !== last_sck) begin
         last_sck = sck;
         if (!cs_n) begin
            if (sck) begin
               rxb = {rxb[6:0], mosi};
               bc++;
               if (bc == 8) begin
                  got.push_back(rxb);
                  bc = 0;
                  if (bi < 15) bi++;
               end
            end else begin
               miso = mb[bi][7-bc];
            end
         end
      end else begin
         bi = 0;
         bc = 0;
         miso = mb[0][7];
      end
   end

   // per-clock reference checks on the serial lines
   logic [31:0] rq [$];
   int cur_hp = SH, prev_hp = SH;
   int hi_cnt = 0, cs_hi = 0, cs_falls = 0;
   int v_r2 = 0, v_r3 = 0, v_r10 = 0, v_r11 = 0;
   bit seen_txn = 1'b0;
   logic p_sck = 1'b0, p_mosi = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs_n && sck) v_r3++;
         if (!busy && !cs_n) v_r3++;
         if (sck && p_sck && mosi !== p_mosi) v_r2++;
         if (sck) hi_cnt++;
         else if (hi_cnt > 0) begin
            if (hi_cnt != cur_hp) v_r10++;
            hi_cnt = 0;
         end
         if (cs_n) begin
            if (cs_hi == 0) prev_hp = cur_hp;
            cs_hi++;
         end else if (cs_hi > 0) begin
            if (seen_txn && cs_hi < prev_hp) v_r11++;
            seen_txn = 1'b1;
            cs_falls++;
            cs_hi = 0;
         end
         if (rvalid) rq.push_back(rdata);
         p_sck = sck;
         p_mosi = mosi;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cmp_bytes(input string req, input logic [7:0] e [$]);
      check(got.size() == e.size(), {req, " byte count"}, got.size(), e.size());
      for (int i = 0; i < e.size() && i < got.size(); i++)
         check(got[i] == e[i], {req, " byte"}, got[i], e[i]);
   endtask

   task automatic launch(input bit w, input bit c, input logic [21:0] a,
                         input logic [7:0] l, input bit fs);
      got.delete();
      rq.delete();
      @(negedge clk);
      rw = w; cmd_mode = c; addr = a; len = l; fast_sel = fs; start = 1'b1;
      cur_hp = fs ? FH : SH;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic feed(input logic [31:0] w, input int dly);
      while (!wready) @(negedge clk);
      for (int i = 0; i < dly; i++) begin
         check(!sck && !cs_n && wready, "R7 stall keeps sck low", {sck, cs_n, wready}, 3'b001);
         @(negedge clk);
      end
      wvalid = 1'b1;
      wdata = w;
      @(negedge clk);
      wvalid = 1'b0;
   endtask

   task automatic wait_done();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] e [$];
      int f0;
      for (int i = 0; i < 16; i++) mb[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset values
      check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
      check(sck == 1'b0, "R1 sck in reset", sck, 0);
      check(busy == 1'b0, "R1 busy in reset", busy, 0);
      check(wready == 1'b0, "R1 wready in reset", wready, 0);
      check(rvalid == 1'b0, "R1 rvalid in reset", rvalid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n && !sck && !busy, "R1 after release", {cs_n, sck, busy}, 3'b100);

      // R8 control frame, rw and len set to odd values
      f0 = cs_falls;
      launch(1'b1, 1'b1, 22'h3F0044, 8'h07, 1'b0);
      wait_done();
      e = '{8'h44, 8'h00, 8'h00};
      cmp_bytes("R8 control frame", e);
      check(cs_falls == f0 + 1, "R8 own chip select", cs_falls - f0, 1);

      // R4 R6 single word write, fast rate
      launch(1'b1, 1'b0, 22'h2A1234, 8'd3, 1'b1);
      feed(32'hDDCCBBAA, 0);
      wait_done();
      e = '{8'hAA, 8'h12, 8'h34, 8'hAA, 8'hBB, 8'hCC, 8'hDD};
      cmp_bytes("R4 write header and R6 lane order", e);

      // R5 R6 two byte read, slow rate, dummy byte answered with FF
      mb[0] = 8'h77; mb[1] = 8'h77; mb[2] = 8'h77; mb[3] = 8'hFF;
      mb[4] = 8'h5A; mb[5] = 8'hC3;
      launch(1'b0, 1'b0, 22'h102468, 8'd1, 1'b0);
      wait_done();
      e = '{8'h10, 8'h24, 8'h68, 8'h00, 8'h00, 8'h00};
      cmp_bytes("R5 read header and dummy", e);
      check(rq.size() == 1, "R6 read word count", rq.size(), 1);
      if (rq.size() > 0) check(rq[0] == 32'h0000C35A, "R5 R6 read data", rq[0], 32'h0000C35A);

      // R7 burst write of six bytes, second word held back
      launch(1'b1, 1'b0, 22'h01ABCD, 8'd5, 1'b1);
      feed(32'h44332211, 0);
      feed(32'h88776655, 10);
      wait_done();
      e = '{8'h81, 8'hAB, 8'hCD, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      cmp_bytes("R7 burst write", e);

      // R6 burst read of six bytes, partial last word
      for (int i = 0; i < 6; i++) mb[4+i] = 8'(i + 1);
      launch(1'b0, 1'b0, 22'h3F0008, 8'd5, 1'b1);
      wait_done();
      e = '{8'h3F, 8'h00, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      cmp_bytes("R7 burst read stream", e);
      check(rq.size() == 2, "R6 burst word count", rq.size(), 2);
      if (rq.size() > 0) check(rq[0] == 32'h04030201, "R6 first word", rq[0], 32'h04030201);
      if (rq.size() > 1) check(rq[1] == 32'h00000605, "R6 partial word", rq[1], 32'h00000605);

      // R9 R10 start and rate switch while a slow read runs
      mb[4] = 8'hE7;
      f0 = cs_falls;
      launch(1'b0, 1'b0, 22'h000123, 8'd0, 1'b0);
      repeat (30) @(negedge clk);
      cmd_mode = 1'b1; addr = 22'h000099; fast_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      e = '{8'h00, 8'h01, 8'h23, 8'h00, 8'h00};
      cmp_bytes("R9 stream unchanged", e);
      check(cs_falls == f0 + 1, "R9 no extra frame", cs_falls - f0, 1);
      check(rq.size() == 1 && rq[0] == 32'h000000E7, "R9 read result", rq.size() > 0 ? rq[0] : 0, 32'hE7);

      check(v_r2 == 0, "R2 mosi moved while sck high", v_r2, 0);
      check(v_r3 == 0, "R3 chip select framing", v_r3, 0);
      check(v_r10 == 0, "R10 sck half-period", v_r10, 0);
      check(v_r11 == 0, "R11 chip select gap", v_r11, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule